// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block derives the bit timing for a UART transmitter and receiver from one functional clock. A prescaler divides the clock by a programmable count of (A+2) to make an oversample strobe. A second counter then divides that strobe by an oversampling factor M to make the per-bit tick. Two mode bits choose M. With the divide enable clear, M is fixed at 16. With the enable set and the direct select clear, M is B+1. With both set, M is 1 and there is no oversampling.

Each mode has a lower limit on its programmed field. While the inputs break the limit of the selected mode, an error flag is raised and the counters run with the clamped minimum value. Divisor and mode inputs are sampled continuously while the generator is stopped. While it runs, they are taken up only at a bit boundary, so no bit is cut short or stretched.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and for as long as `run` is low, `sampleTick` and `bitTick` stay low.
- R2: With `xEnable`=0 (any `xOne`), `sampleTick` repeats every A+2 cycles and `bitTick` repeats every 16*(A+2) cycles.
- R3: With `xEnable`=1 and `xOne`=0 and B>=8, `bitTick` repeats every (B+1)*(A+2) cycles, with B+1 sample strobes per bit.
- R4: With `xEnable`=1 and `xOne`=1 and A>=3, both outputs repeat every A+2 cycles and `sampleTick` equals `bitTick` on every cycle.
- R5: In the (B+1) mode with B<8, `cfgError` is 1 and bits last 9*(A+2) cycles. With B>=8, `cfgError` is 0.
- R6: In the direct mode with A<3, `cfgError` is 1 and both outputs repeat every 5 cycles. With A>=3, `cfgError` is 0.
- R7: In the fixed x16 mode, `cfgError` is 0 for every A and B.
- R8: When `run` is first sampled high at clock edge 1, the first `sampleTick` is high after edge A'+2. The first `bitTick` is high after edge M*(A'+2), where A' is the clamped A.
- R9: A change to the divisor or mode inputs while running leaves the current bit at its old length. The new period applies from the next bit boundary on.
- R10: `sampleTick` and `bitTick` are single-cycle pulses, and `bitTick` is high only together with `sampleTick`.
- R11: Dropping `run` clears the count phase. Raising it again restarts timing as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counting enable; low holds phase at zero and reloads the settings |
| divA | input | 16 | Prescale field A; the prescaler counts A+2 clocks |
| divB | input | 4 | Oversample field B; M = B+1 in the programmable mode |
| xEnable | input | 1 | 0: fixed x16 oversampling; 1: mode chosen by `xOne` |
| xOne | input | 1 | With `xEnable`=1: 0 selects the (B+1) mode, 1 selects the direct divide |
| sampleTick | output | 1 | One-cycle oversample strobe |
| bitTick | output | 1 | One-cycle bit strobe |
| cfgError | output | 1 | Inputs violate the minimum of the selected mode (combinational) |

## Verification
Both tick outputs are registered. A pulse due at count edge n is high in the cycle after edge n, so the bench samples on the falling edge after each rising edge and numbers those samples from the first edge at which `run` is high. It predicts the first sample strobe at edge A'+2 and the first bit tick at edge M*(A'+2), with the next bit tick one period later, all worked out from the requirements. `cfgError` has no register in its path, so the bench reads it half a cycle after changing the fields. A mid-run change is applied at a known edge, and the bench expects the old bit length to finish before the new period begins.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [1:0] {
    MODE_X16    = 2'd0,
    MODE_XB     = 2'd1,
    MODE_DIRECT = 2'd2
  } baud_mode_e;

  // control -> datapath
  typedef struct packed {
    logic clear;   // hold phase at zero
    logic count;   // advance counters
    logic load;    // take new divisor settings
  } baud_ctrl_t;

  // datapath -> control
  typedef struct packed {
    logic preLast; // prescaler at terminal count
    logic ovsLast; // oversample counter at terminal count
  } baud_stat_t;

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BW       = 4,
  parameter int FIX_OVS  = 16,
  parameter int MIN_B    = 8,
  parameter int MIN_A    = 3,
  localparam int PW      = AW + 1,
  localparam int MW      = BW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic [AW-1:0] divA,
  input  logic [BW-1:0] divB,
  input  logic          xEnable,
  input  logic          xOne,
  input  baud_stat_t    stat,
  output baud_ctrl_t    ctrl,
  output logic [PW-1:0] nextP,
  output logic [MW-1:0] nextM,
  output logic          cfgError
);

  baud_mode_e    mode;
  logic          aLow;
  logic          bLow;
  logic [AW-1:0] aEff;
  logic [BW-1:0] bEff;

  always_comb begin
    if (!xEnable)  mode = MODE_X16;
    else if (xOne) mode = MODE_DIRECT;
    else           mode = MODE_XB;
  end

  assign aLow = (divA < AW'(MIN_A));
  assign bLow = (divB < BW'(MIN_B));

  always_comb begin
    aEff     = divA;
    bEff     = divB;
    cfgError = 1'b0;
    unique case (mode)
      MODE_XB: begin
        cfgError = bLow;
        if (bLow) bEff = BW'(MIN_B);
      end
      MODE_DIRECT: begin
        cfgError = aLow;
        if (aLow) aEff = AW'(MIN_A);
      end
      default: ;
    endcase
  end

  always_comb begin
    nextP = PW'(aEff) + PW'(2);
    unique case (mode)
      MODE_X16:    nextM = MW'(FIX_OVS);
      MODE_XB:     nextM = MW'(bEff) + MW'(1);
      MODE_DIRECT: nextM = MW'(1);
      default:     nextM = MW'(FIX_OVS);
    endcase
  end

  always_comb begin
    ctrl.clear = !run;
    ctrl.count = run;
    ctrl.load  = !run || (stat.preLast && stat.ovsLast);
  end

  AST_CLAMP_XB: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_XB) |-> (nextM >= MW'(MIN_B + 1))) else $error("AST_CLAMP_XB"); // R5
  AST_CLAMP_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DIRECT) |-> (nextP >= PW'(MIN_A + 2) && nextM == MW'(1))) else $error("AST_CLAMP_DIRECT"); // R6

endmodule

// File: rtl/baud_dp.sv
module baud_dp
  import baud_pkg::*;
#(
  parameter int AW  = 16,
  parameter int BW  = 4,
  localparam int PW = AW + 1,
  localparam int MW = BW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  baud_ctrl_t    ctrl,
  input  logic [PW-1:0] nextP,
  input  logic [MW-1:0] nextM,
  output baud_stat_t    stat,
  output logic          sampleTick,
  output logic          bitTick
);

  logic [PW-1:0] actP;
  logic [MW-1:0] actM;
  logic [PW-1:0] pre;
  logic [MW-1:0] ovs;

  assign stat.preLast = (pre == actP - PW'(1));
  assign stat.ovsLast = (ovs == actM - MW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actP <= PW'(2);
      actM <= MW'(1);
    end else if (ctrl.load) begin
      actP <= nextP;
      actM <= nextM;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre        <= '0;
      ovs        <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else if (ctrl.clear) begin
      pre        <= '0;
      ovs        <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else if (ctrl.count) begin
      sampleTick <= stat.preLast;
      bitTick    <= stat.preLast && stat.ovsLast;
      if (stat.preLast) begin
        pre <= '0;
        ovs <= stat.ovsLast ? '0 : ovs + MW'(1);
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pre < actP) && (ovs < actM)) else $error("AST_NO_OVERFLOW"); // R2
  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |=> !sampleTick) else $error("AST_SAMPLE_PULSE"); // R10
  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick) else $error("AST_BIT_WITH_SAMPLE"); // R10
  AST_DIRECT_SAME: assert property (@(posedge clk) disable iff (!rstN)
    (actM == MW'(1)) |-> (bitTick == sampleTick)) else $error("AST_DIRECT_SAME"); // R4
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.count && !(stat.preLast && stat.ovsLast)) |=> ($stable(actP) && $stable(actM))) else $error("AST_HOLD_CFG"); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clear |=> (!sampleTick && !bitTick)) else $error("AST_IDLE_QUIET"); // R1

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int AW      = 16,
  parameter int BW      = 4,
  parameter int FIX_OVS = 16,
  parameter int MIN_B   = 8,
  parameter int MIN_A   = 3,
  localparam int PW     = AW + 1,
  localparam int MW     = BW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          run,
  input  logic [AW-1:0] divA,
  input  logic [BW-1:0] divB,
  input  logic          xEnable,
  input  logic          xOne,
  output logic          sampleTick,
  output logic          bitTick,
  output logic          cfgError
);

  baud_ctrl_t    ctrl;
  baud_stat_t    stat;
  logic [PW-1:0] nextP;
  logic [MW-1:0] nextM;

  baud_ctrl #(
    .AW(AW), .BW(BW), .FIX_OVS(FIX_OVS), .MIN_B(MIN_B), .MIN_A(MIN_A)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .divA(divA), .divB(divB),
    .xEnable(xEnable), .xOne(xOne), .stat(stat), .ctrl(ctrl),
    .nextP(nextP), .nextM(nextM), .cfgError(cfgError)
  );

  baud_dp #(
    .AW(AW), .BW(BW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .nextP(nextP), .nextM(nextM),
    .stat(stat), .sampleTick(sampleTick), .bitTick(bitTick)
  );

endmodule

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic [15:0] divA = '0;
  logic [3:0]  divB = '0;
  logic        xEnable = 1'b0;
  logic        xOne = 1'b0;
  logic        sampleTick;
  logic        bitTick;
  logic        cfgError;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rstN(rstN), .run(run), .divA(divA), .divB(divB),
    .xEnable(xEnable), .xOne(xOne),
    .sampleTick(sampleTick), .bitTick(bitTick), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one setting from phase zero; expP/expM follow the requirements.
  task automatic runCfg(input int a, input int b, input bit xe, input bit xo,
                        input int expP, input int expM, input bit expErr, input string req);
    int firstSmp = 0, firstBit = 0, secondBit = 0, smpBefore = 0;
    int dbl = 0, mism = 0;
    bit prevS = 0, prevB = 0;
    @(negedge clk);
    run = 0; divA = 16'(a); divB = 4'(b); xEnable = xe; xOne = xo;
    @(negedge clk);
    check(cfgError == expErr, {req, " cfgError"}, cfgError, expErr);
    run = 1;
    for (int n = 1; n <= 2 * expP * expM + 2; n++) begin
      @(negedge clk);
      if (sampleTick && firstSmp == 0) firstSmp = n;
      if (sampleTick && firstBit == 0) smpBefore++;
      if (bitTick) begin
        if (firstBit == 0) firstBit = n;
        else if (secondBit == 0) secondBit = n;
      end
      if ((sampleTick && prevS) || (bitTick && prevB)) dbl++;
      if (bitTick && !sampleTick) mism++;
      if (expM == 1 && sampleTick != bitTick) mism++;
      prevS = sampleTick; prevB = bitTick;
    end
    run = 0;
    check(firstSmp == expP, {req, " R8 first sampleTick edge"}, firstSmp, expP);
    check(firstBit == expP * expM, {req, " R8 first bitTick edge"}, firstBit, expP * expM);
    check(secondBit - firstBit == expP * expM, {req, " bit period"}, secondBit - firstBit, expP * expM);
    check(smpBefore == expM, {req, " samples per bit"}, smpBefore, expM);
    check(dbl == 0, "R10 single-cycle pulses", dbl, 0);
    check(mism == 0, "R10/R4 bitTick vs sampleTick", mism, 0);
  endtask

  initial begin
    #1_500_000;
    nFails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int quiet;
    int b1, b2;
    repeat (3) @(negedge clk);
    check(sampleTick == 0 && bitTick == 0, "R1 reset outputs", int'(sampleTick) + int'(bitTick), 0);
    rstN = 1;
    quiet = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sampleTick || bitTick) quiet++;
    end
    check(quiet == 0, "R1 idle with run low", quiet, 0);

    for (int a = 0; a <= 5; a++)
      runCfg(a, 15 - a, 1'b0, a[0], a + 2, 16, 1'b0, "R2 R7 x16");

    for (int a = 0; a <= 3; a++)
      for (int b = 0; b <= 15; b++) begin
        if (b >= 8) runCfg(a, b, 1'b1, 1'b0, a + 2, b + 1, 1'b0, "R3 xB");
        else        runCfg(a, b, 1'b1, 1'b0, a + 2, 9, 1'b1, "R5 xB clamp");
      end

    for (int a = 0; a <= 7; a++) begin
      if (a >= 3) runCfg(a, 0, 1'b1, 1'b1, a + 2, 1, 1'b0, "R4 direct");
      else        runCfg(a, 0, 1'b1, 1'b1, 5, 1, 1'b1, "R6 direct clamp");
    end
    runCfg(1000, 3, 1'b1, 1'b1, 1002, 1, 1'b0, "R4 direct large");
    runCfg(40, 0, 1'b0, 1'b0, 42, 16, 1'b0, "R2 x16 larger A");

    // R9: x16, A=1 (48-cycle bit); at edge 10 switch to direct A=4 (6-cycle bit)
    @(negedge clk);
    run = 0; divA = 16'd1; divB = 4'd0; xEnable = 0; xOne = 0;
    @(negedge clk);
    run = 1;
    b1 = 0; b2 = 0;
    for (int n = 1; n <= 70; n++) begin
      @(negedge clk);
      if (n == 10) begin divA = 16'd4; xEnable = 1; xOne = 1; end
      if (bitTick) begin
        if (b1 == 0) b1 = n;
        else if (b2 == 0) b2 = n;
      end
    end
    check(b1 == 48, "R9 current bit keeps old length", b1, 48);
    check(b2 == 54, "R9 new period after boundary", b2, 54);

    // R11: drop run mid-bit, restart x16 A=2 from phase zero
    @(negedge clk);
    run = 0; divA = 16'd2; xEnable = 0; xOne = 0;
    @(negedge clk);
    run = 1;
    repeat (20) @(negedge clk);
    run = 0;
    @(negedge clk);
    check(sampleTick == 0 && bitTick == 0, "R11 outputs low after stop", int'(sampleTick) + int'(bitTick), 0);
    run = 1;
    b1 = 0;
    for (int n = 1; n <= 70; n++) begin
      @(negedge clk);
      if (bitTick && b1 == 0) b1 = n;
    end
    run = 0;
    check(b1 == 64, "R11 restart from phase zero", b1, 64);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule